// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 32-bit binary operands and a carry-in in a single combinational pass. It finds carries by lookahead rather than by passing a carry from bit to bit. The operand bits form four 8-bit groups. Inside each group, every bit derives a generate term (both operand bits set) and a propagate term (either operand bit set). From these, the group computes each internal carry as a flat sum of products, using only its own terms and the carry entering the group. Each group also reduces its terms to one group generate and one group propagate.

A second lookahead stage takes the four group term pairs and the external carry-in. It returns the carry entering every group boundary and the final carry-out, again as flat sums of products. For comparison, an elaboration parameter can replace this stage with a simple ripple of group carries from one group to the next. Both variants give the same result.

The block has no clock and no state. It is meant to sit in a larger datapath that registers its result wherever timing requires.

Top module: `cla_adder32`

## Requirements
- R1: `sumOut` equals the low 32 bits of `opA + opB + carryIn`, with the operands taken as unsigned.
- R2: `carryOut` equals bit 32 of the unsigned 33-bit total `opA + opB + carryIn`.
- R3: `overflow` is 1 exactly when `opA[31]` equals `opB[31]` and `sumOut[31]` differs from them. This is equal to the XOR of the carry into bit 31 and the carry out of bit 31.
- R4: Adding 0xFFFFFFFF and 0x00000000 with `carryIn` = 1 gives `sumOut` = 0, `carryOut` = 1 and `overflow` = 0. The carry-in crosses every group boundary.
- R5: Adding 0x7FFFFFFF and 0x00000001 with `carryIn` = 0 gives `sumOut` = 0x80000000, `carryOut` = 0 and `overflow` = 1.
- R6: A carry generated in the top bit of group k (operand bit 8k+7) reaches bit 8(k+1). For example, 0x80 shifted left by 8k and added to itself gives 0x100 shifted left by 8k. This holds at each of the three inner boundaries. At the last group, it produces `carryOut` = 1.
- R7: The ripple variant (`LOOKAHEAD` = 0) produces the same `sumOut`, `carryOut` and `overflow` as the lookahead variant for every input.
- R8: Zero plus zero with `carryIn` = 0 gives `sumOut` = 0, `carryOut` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 32 | Sum bits |
| carryOut | output | 1 | Carry out of bit 31 |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
The block holds no state, so any fault in its terms shows up at the ports for the same input vector. A broken term shows up only for operands that use it.

- A wrong bit generate or propagate term, or a wrong in-group carry term, corrupts the sum bits above that position. It shows only when a carry has to pass through that term.
- A wrong group term or second-level product corrupts a whole group, or the carry-out. It shows only when a carry must cross that boundary, so the boundary-crossing patterns and the all-ones-plus-carry pattern are the ones that expose it.
- Running both variants side by side catches a lookahead product that disagrees with the plain group ripple.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int MAX_TERMS = 64;

  typedef logic [MAX_TERMS-1:0] termVec_t;

  // Carry into position n of a chain, as a flat sum of products of the
  // generate/propagate terms below n and the chain's entry carry.
  function automatic logic flatCarry(input termVec_t gen, input termVec_t prop,
                                     input logic entryCarry, input int n);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int m = 0; m < MAX_TERMS; m++) begin
      if (m < n) begin
        prod = gen[m];
        for (int l = 0; l < MAX_TERMS; l++) begin
          if (l > m && l < n) prod = prod & prop[l];
        end
        acc = acc | prod;
      end
    end
    prod = entryCarry;
    for (int l = 0; l < MAX_TERMS; l++) begin
      if (l < n) prod = prod & prop[l];
    end
    return acc | prod;
  endfunction

endpackage

// File: rtl/claGroup.sv
module claGroup
  import cla_pkg::*;
#(
  parameter int GROUP_W = 8
) (
  input  logic [GROUP_W-1:0] xIn,
  input  logic [GROUP_W-1:0] yIn,
  input  logic               groupCin,
  output logic [GROUP_W-1:0] sumBits,
  output logic               groupGen,
  output logic               groupProp,
  output logic               msbCarry
);

  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W-1:0] bitCarry;
  termVec_t genExt;
  termVec_t propExt;

  assign bitGen  = xIn & yIn;
  assign bitProp = xIn | yIn;
  assign genExt  = termVec_t'(bitGen);
  assign propExt = termVec_t'(bitProp);

  genvar j;
  generate
    for (j = 0; j < GROUP_W; j++) begin : g_carry
      if (j == 0) begin : g_first
        assign bitCarry[j] = groupCin;
      end else begin : g_rest
        assign bitCarry[j] = flatCarry(genExt, propExt, groupCin, j);
      end
    end
  endgenerate

  assign sumBits   = xIn ^ yIn ^ bitCarry;
  assign groupGen  = flatCarry(genExt, propExt, 1'b0, GROUP_W);
  assign groupProp = &bitProp;
  assign msbCarry  = bitCarry[GROUP_W-1];

endmodule

// File: rtl/claSecondLevel.sv
module claSecondLevel
  import cla_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter bit LOOKAHEAD  = 1'b1
) (
  input  logic [NUM_GROUPS-1:0] grpGen,
  input  logic [NUM_GROUPS-1:0] grpProp,
  input  logic                  carryIn,
  output logic [NUM_GROUPS:0]   grpCarry
);

  termVec_t genExt;
  termVec_t propExt;

  assign genExt      = termVec_t'(grpGen);
  assign propExt     = termVec_t'(grpProp);
  assign grpCarry[0] = carryIn;

  genvar k;
  generate
    if (LOOKAHEAD) begin : g_look
      for (k = 0; k < NUM_GROUPS; k++) begin : g_bound
        assign grpCarry[k+1] = flatCarry(genExt, propExt, carryIn, k + 1);
      end
    end else begin : g_ripple
      for (k = 0; k < NUM_GROUPS; k++) begin : g_bound
        assign grpCarry[k+1] = grpGen[k] | (grpProp[k] & grpCarry[k]);
      end
    end
  endgenerate

endmodule

// File: rtl/cla_adder32.sv
module cla_adder32
  import cla_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GROUP_W   = 8,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              overflow
);

  localparam int NUM_GROUPS = DATA_W / GROUP_W;

  logic [NUM_GROUPS-1:0] grpGen;
  logic [NUM_GROUPS-1:0] grpProp;
  logic [NUM_GROUPS-1:0] grpMsbCarry;
  logic [NUM_GROUPS:0]   grpCarry;

  initial begin
    if (GROUP_W > MAX_TERMS || NUM_GROUPS > MAX_TERMS || NUM_GROUPS * GROUP_W != DATA_W)
      $error("cla_adder32: unsupported width split");
  end

  genvar k;
  generate
    for (k = 0; k < NUM_GROUPS; k++) begin : g_grp
      claGroup #(.GROUP_W(GROUP_W)) u_grp (
        .xIn      (opA[k*GROUP_W +: GROUP_W]),
        .yIn      (opB[k*GROUP_W +: GROUP_W]),
        .groupCin (grpCarry[k]),
        .sumBits  (sumOut[k*GROUP_W +: GROUP_W]),
        .groupGen (grpGen[k]),
        .groupProp(grpProp[k]),
        .msbCarry (grpMsbCarry[k])
      );
    end
  endgenerate

  claSecondLevel #(.NUM_GROUPS(NUM_GROUPS), .LOOKAHEAD(LOOKAHEAD)) u_lvl2 (
    .grpGen  (grpGen),
    .grpProp (grpProp),
    .carryIn (carryIn),
    .grpCarry(grpCarry)
  );

  assign carryOut = grpCarry[NUM_GROUPS];
  assign overflow = grpMsbCarry[NUM_GROUPS-1] ^ grpCarry[NUM_GROUPS];

endmodule

// File: rtl/cla_adder32_chk.sv
module cla_adder32_chk #(
  parameter int DATA_W     = 32,
  parameter int GROUP_W    = 8,
  parameter int NUM_GROUPS = 4
) (
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic                carryIn,
  input logic [DATA_W-1:0]   sumOut,
  input logic                carryOut,
  input logic                overflow,
  input logic [NUM_GROUPS:0] grpCarry
);

  logic [DATA_W:0] refTotal;
  logic [NUM_GROUPS:0] refBound;

  always_comb begin
    refTotal = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
    for (int k = 0; k <= NUM_GROUPS; k++) begin
      logic [DATA_W:0] mask;
      logic [DATA_W:0] part;
      mask = ({{DATA_W{1'b0}}, 1'b1} << (k * GROUP_W)) - 1'b1;
      part = ({1'b0, opA} & mask) + ({1'b0, opB} & mask) + {{DATA_W{1'b0}}, carryIn};
      refBound[k] = part[k * GROUP_W];
    end
  end

  always_comb begin
    // R1
    sum_match_chk: assert (sumOut == refTotal[DATA_W-1:0])
      else $error("sum mismatch");
    // R2
    carry_out_chk: assert (carryOut == refTotal[DATA_W])
      else $error("carry-out mismatch");
    // R3
    ovf_rule_chk: assert (overflow == ((opA[DATA_W-1] == opB[DATA_W-1]) &&
                                       (sumOut[DATA_W-1] != opA[DATA_W-1])))
      else $error("overflow mismatch");
    // R6
    boundary_carry_chk: assert (grpCarry == refBound)
      else $error("group boundary carry mismatch");
    // R8
    zero_add_chk: assert (!(opA == '0 && opB == '0 && !carryIn) ||
                          (sumOut == '0 && !carryOut && !overflow))
      else $error("zero add mismatch");
  end

endmodule

bind cla_adder32 cla_adder32_chk #(
  .DATA_W(DATA_W), .GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut),
  .carryOut(carryOut), .overflow(overflow), .grpCarry(grpCarry)
);

// File: tb/sim_cla_adder32.sv
module sim_cla_adder32;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [W-1:0] expSum;
    logic         expCout;
    logic         expOvf;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum0, sum1;
  logic cout0, cout1, ovf0, ovf1;

  int total = 0;
  int bad = 0;
  bit driveDone = 1'b0;
  item_t sbQueue[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cla_adder32 #(.LOOKAHEAD(1'b1)) u0 (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sum0), .carryOut(cout0), .overflow(ovf0)
  );

  cla_adder32 #(.LOOKAHEAD(1'b0)) u1 (
    .opA(a), .opB(b), .carryIn(cin), .sumOut(sum1), .carryOut(cout1), .overflow(ovf1)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c, input string tag);
    item_t it;
    logic [W:0] t;
    @(posedge clk);
    a = x;
    b = y;
    cin = c;
    t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    it.a = x;
    it.b = y;
    it.cin = c;
    it.expSum = t[W-1:0];
    it.expCout = t[W];
    it.expOvf = (x[W-1] == y[W-1]) && (t[W-1] != x[W-1]);
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  // Monitor: samples on the falling edge, half a period after each drive.
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (sbQueue.size() > 0) begin
        item_t it;
        it = sbQueue.pop_front();
        check({it.tag, " R1 sum"}, sum0, it.expSum);
        check({it.tag, " R2 cout"}, W'(cout0), W'(it.expCout));
        check({it.tag, " R3 ovf"}, W'(ovf0), W'(it.expOvf));
        check({it.tag, " R7 sum ripple"}, sum1, sum0);
        check({it.tag, " R7 flags ripple"}, W'({cout1, ovf1}), W'({cout0, ovf0}));
      end else if (driveDone) begin
        break;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: idle state, zero operands
    #(CLK_PERIOD * 2 + 1);
    check("R8 sum", sum0, '0);
    check("R8 flags", W'({cout0, ovf0}), '0);
    rstN = 1'b1;
    drive(32'h0, 32'h0, 1'b0, "R8");
    drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R4");
    drive(32'h0, 32'hFFFF_FFFF, 1'b1, "R4 swap");
    drive(32'h7FFF_FFFF, 32'h1, 1'b0, "R5");
    drive(32'h7FFF_FFFF, 32'h0, 1'b1, "R5 cin");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 neg");
    for (int k = 0; k < 4; k++) begin
      drive(32'h80 << (8 * k), 32'h80 << (8 * k), 1'b0, "R6");
      drive(32'hFF << (8 * k), 32'h01 << (8 * k), 1'b0, "R6 prop");
    end
    for (int n = 0; n < 2000; n++) begin
      drive($urandom, $urandom, 1'($urandom), "R1 rand");
    end
    @(posedge clk);
    driveDone = 1'b1;
  end

endmodule